// File: doc/BRIEF.md
# Serial NOR Flash Command and Address-Width Front End

This block sits on the device side of a serial NOR flash. It watches the SPI pins (chip select, serial clock and data in), gathers bytes while the device is selected, and decodes the first byte of each transaction as an opcode. From that opcode, and from a sticky address-width flag, it works out how many address bytes follow. Once the last address byte arrives, it reports the command kind and a 32-bit address on registered outputs for one clock.

The flag has two states, 3-byte and 4-byte. It is set and cleared only by dedicated opcodes or by reset. Deselecting the device does not change it. The legacy read, program and erase opcodes follow the flag. A second set of opcodes always carries four address bytes and ignores the flag. A three-byte address reaches 16 MiB. Larger arrays need the four-byte forms or the 4-byte state.

The SPI pins are sampled by the system clock through synchronisers. The serial clock must therefore be several times slower than the system clock. Storage, program and erase timing, and status reporting belong to other blocks.

Top module: `flash_addr_frontend`

## Requirements
- R1: After reset the width flag `addr4_mode` is 0 (3-byte state), and neither `cmd_valid` nor `cmd_invalid` is asserted.
- R2: In the 3-byte state, opcode 0x03 (read), 0x02 (program) and 0xD8 (erase) each take three address bytes. The first address byte is the most significant, and bits 31:24 of `cmd_addr` read as zero.
- R3: Opcodes 0x13 (read), 0x0C (fast read), 0x12 (program) and 0xDC (erase) take four address bytes in both width states. The first address byte lands in `cmd_addr[31:24]`.
- R4: Opcode 0xB7 takes no address. It sets `addr4_mode` to 1 and is reported as kind 4 with address 0. From then on, 0x03, 0x02 and 0xD8 take four address bytes.
- R5: Opcode 0xE9 takes no address. It clears `addr4_mode` and is reported as kind 5 with address 0. From then on, the legacy opcodes take three address bytes again.
- R6: The width flag keeps its value while the device is deselected and across any number of transactions.
- R7: Asserting `rst` returns the flag to the 3-byte state.
- R8: Raising `cs_n` before the address is complete drops the partial command without any report. It leaves the flag unchanged, and the next selection starts with a fresh opcode.
- R9: An opcode outside the listed set raises `cmd_invalid` for one clock. Every further byte in that selection is ignored.
- R10: Bytes that follow a completed command in the same selection are ignored, including the width opcodes.
- R11: `cmd_kind` encodes read=0, fast read=1, program=2, erase=3, enter 4-byte=4 and exit 4-byte=5. `cmd_valid` is a single-clock pulse, and `cmd_kind`/`cmd_addr` are valid with it.
- R12: Bits are taken on the rising edge of `sck` (SPI mode 0), most significant bit first, eight bits to a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also stands in for the flash reset pin |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data into the device |
| cmd_valid | output | 1 | One-clock pulse when a command is fully decoded |
| cmd_kind | output | 3 | Command kind, encoded as in R11 |
| cmd_addr | output | 32 | Decoded address; zero for the width opcodes |
| cmd_invalid | output | 1 | One-clock pulse on an unrecognised opcode |
| addr4_mode | output | 1 | Current width flag, 1 = 4-byte state |

## Verification
The assertions assume that the serial clock is slow against the system clock. Each `sck` level must last at least a few system clocks, so that a full byte spans many clocks and two reports can never fall in adjacent cycles. They also assume that `mosi` and `cs_n` change only while `sck` is low. The bench drives each `sck` phase for four system clocks and changes data on falling clock edges. It changes chip select only with `sck` low and a margin of several clocks on either side, and it applies reset only while the device is deselected.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [2:0] {
    K_READ   = 3'd0,
    K_FREAD  = 3'd1,
    K_PROG   = 3'd2,
    K_ERASE  = 3'd3,
    K_ENTER4 = 3'd4,
    K_EXIT4  = 3'd5
  } cmd_kind_t;

  localparam logic [7:0] OP_READ3   = 8'h03;
  localparam logic [7:0] OP_PROG3   = 8'h02;
  localparam logic [7:0] OP_ERASE3  = 8'hD8;
  localparam logic [7:0] OP_READ4   = 8'h13;
  localparam logic [7:0] OP_FREAD4  = 8'h0C;
  localparam logic [7:0] OP_PROG4   = 8'h12;
  localparam logic [7:0] OP_ERASE4  = 8'hDC;
  localparam logic [7:0] OP_ENTER4  = 8'hB7;
  localparam logic [7:0] OP_EXIT4   = 8'hE9;

endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              sel,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sck_s, cs_s, mosi_s;
  logic                   sck_prev;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-1:0]      shreg;
  logic                   sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[SYNC_STAGES-2:0], sck};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sel      = ~cs_s[SYNC_STAGES-1];
  assign sck_rise = sck_s[SYNC_STAGES-1] & ~sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev   <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      sck_prev   <= sck_s[SYNC_STAGES-1];
      byte_valid <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[BYTE_W-2:0], mosi_s[SYNC_STAGES-1]};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          byte_valid <= 1'b1;
          byte_data  <= {shreg[BYTE_W-2:0], mosi_s[SYNC_STAGES-1]};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R8: deselection leaves no byte to be delivered on the next clock
  p_no_byte_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !byte_valid);

  // R12: a byte needs eight slow clock edges, so strobes never touch
  p_byte_strobe_single_r12: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

endmodule

// File: rtl/opcode_decode.sv
module opcode_decode
  import flash_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NB_W   = 3,
  parameter int WIDE_N = 4
) (
  input  logic [BYTE_W-1:0] opcode,
  input  logic              wide_mode,
  output logic              known,
  output cmd_kind_t         kind,
  output logic [NB_W-1:0]   nbytes,
  output logic              set_wide,
  output logic              clr_wide
);
  localparam logic [NB_W-1:0] N_WIDE   = NB_W'(WIDE_N);
  localparam logic [NB_W-1:0] N_NARROW = NB_W'(WIDE_N - 1);

  logic [NB_W-1:0] legacy_n;
  assign legacy_n = wide_mode ? N_WIDE : N_NARROW;

  always_comb begin
    known    = 1'b1;
    kind     = K_READ;
    nbytes   = '0;
    set_wide = 1'b0;
    clr_wide = 1'b0;
    case (opcode)
      OP_READ3:  begin kind = K_READ;  nbytes = legacy_n; end
      OP_PROG3:  begin kind = K_PROG;  nbytes = legacy_n; end
      OP_ERASE3: begin kind = K_ERASE; nbytes = legacy_n; end
      OP_READ4:  begin kind = K_READ;  nbytes = N_WIDE;   end
      OP_FREAD4: begin kind = K_FREAD; nbytes = N_WIDE;   end
      OP_PROG4:  begin kind = K_PROG;  nbytes = N_WIDE;   end
      OP_ERASE4: begin kind = K_ERASE; nbytes = N_WIDE;   end
      OP_ENTER4: begin kind = K_ENTER4; set_wide = 1'b1;  end
      OP_EXIT4:  begin kind = K_EXIT4;  clr_wide = 1'b1;  end
      default:   known = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_addr_frontend.sv
module flash_addr_frontend
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_invalid,
  output logic              addr4_mode
);
  localparam int ABYTES = ADDR_W / BYTE_W;
  localparam int NB_W   = $clog2(ABYTES + 1);

  typedef enum logic [1:0] {ST_OPCODE, ST_ADDR, ST_SKIP} st_t;

  logic              sel, byte_valid;
  logic [BYTE_W-1:0] byte_data;
  logic              dec_known, dec_set, dec_clr;
  cmd_kind_t         dec_kind, pend_kind, kind_q;
  logic [NB_W-1:0]   dec_nbytes, remain;
  logic [ADDR_W-1:0] addr_sh, addr_next;
  st_t               st;

  spi_byte_rx #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sel(sel), .byte_valid(byte_valid), .byte_data(byte_data)
  );

  opcode_decode #(.BYTE_W(BYTE_W), .NB_W(NB_W), .WIDE_N(ABYTES)) u_dec (
    .opcode(byte_data), .wide_mode(addr4_mode), .known(dec_known),
    .kind(dec_kind), .nbytes(dec_nbytes), .set_wide(dec_set),
    .clr_wide(dec_clr)
  );

  assign addr_next = {addr_sh[ADDR_W-BYTE_W-1:0], byte_data};
  assign cmd_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_OPCODE;
      addr4_mode  <= 1'b0;
      remain      <= '0;
      addr_sh     <= '0;
      pend_kind   <= K_READ;
      kind_q      <= K_READ;
      cmd_valid   <= 1'b0;
      cmd_invalid <= 1'b0;
      cmd_addr    <= '0;
    end else begin
      cmd_valid   <= 1'b0;
      cmd_invalid <= 1'b0;
      if (!sel) begin
        st     <= ST_OPCODE;
        remain <= '0;
      end else if (byte_valid) begin
        case (st)
          ST_OPCODE: begin
            if (!dec_known) begin
              cmd_invalid <= 1'b1;
              st          <= ST_SKIP;
            end else if (dec_set || dec_clr) begin
              addr4_mode <= dec_set;
              cmd_valid  <= 1'b1;
              kind_q     <= dec_kind;
              cmd_addr   <= '0;
              st         <= ST_SKIP;
            end else begin
              pend_kind <= dec_kind;
              remain    <= dec_nbytes;
              addr_sh   <= '0;
              st        <= ST_ADDR;
            end
          end
          ST_ADDR: begin
            addr_sh <= addr_next;
            remain  <= remain - 1'b1;
            if (remain == NB_W'(1)) begin
              cmd_valid <= 1'b1;
              cmd_addr  <= addr_next;
              kind_q    <= pend_kind;
              st        <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: the flag only rises with an enter-4-byte report
  p_mode_rise_enter_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(addr4_mode) |-> (cmd_valid && cmd_kind == K_ENTER4));

  // R5/R7: the flag only falls on an exit report or after reset
  p_mode_fall_exit_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(addr4_mode) |-> ($past(rst) || (cmd_valid && cmd_kind == K_EXIT4)));

  // R11: a report is a single-clock pulse
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R9: invalid and valid reports never coincide, and invalid is a pulse
  p_invalid_excl_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_invalid |-> !cmd_valid);
  p_invalid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_invalid |=> !cmd_invalid);

  // R8: nothing is reported on the clock after the device is found deselected
  p_idle_silent_r8: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !(cmd_valid || cmd_invalid));

endmodule

// File: tb/flash_addr_frontend_tb.sv
module flash_addr_frontend_tb;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        cmd_valid, cmd_invalid, addr4_mode;
  logic [2:0]  cmd_kind;
  logic [31:0] cmd_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          inv;
    logic [2:0]  kind;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  flash_addr_frontend u_dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_invalid(cmd_invalid), .addr4_mode(addr4_mode)
  );

  // monitor: every report pops one expected item
  always @(negedge clk) begin
    if (!rst && (cmd_valid || cmd_invalid)) begin
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected report: valid=%0b invalid=%0b kind=%0d addr=%h, expected none",
                 cmd_valid, cmd_invalid, cmd_kind, cmd_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.inv) begin
          if (!cmd_invalid || cmd_valid) begin
            n_fail++;
            $display("FAIL %s invalid report: valid=%0b invalid=%0b, expected valid=0 invalid=1",
                     e.tag, cmd_valid, cmd_invalid);
          end
        end else if (!cmd_valid || cmd_kind != e.kind || cmd_addr != e.addr) begin
          n_fail++;
          $display("FAIL %s R11 command: valid=%0b kind=%0d addr=%h, expected valid=1 kind=%0d addr=%h",
                   e.tag, cmd_valid, cmd_kind, cmd_addr, e.kind, e.addr);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [2:0] k, input logic [31:0] a, input string tag);
    exp_t e;
    e.inv = 1'b0; e.kind = k; e.addr = a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic expect_inv(input string tag);
    exp_t e;
    e.inv = 1'b1; e.kind = '0; e.addr = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  // R12: MSB first, data changes while sck is low
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = b[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input logic [7:0] b4, input int n);
    logic [7:0] bs [5];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4;
    select();
    for (int i = 0; i < n; i++) send_byte(bs[i]);
    deselect();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(addr4_mode == 1'b0, "R1 mode after reset", 32'(addr4_mode), 32'd0);
    check(!cmd_valid && !cmd_invalid, "R1 quiet after reset",
          {30'd0, cmd_valid, cmd_invalid}, 32'd0);

    // R2 / R12 legacy opcodes in the 3-byte state
    expect_cmd(3'd0, 32'h0012_3456, "R2 read3");
    xfer(8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 4);
    expect_cmd(3'd2, 32'h00AB_CDEF, "R2 prog3");
    xfer(8'h02, 8'hAB, 8'hCD, 8'hEF, 8'h00, 4);
    expect_cmd(3'd3, 32'h0001_0203, "R2 erase3");
    xfer(8'hD8, 8'h01, 8'h02, 8'h03, 8'h00, 4);

    // R3 four-byte opcodes in the 3-byte state
    expect_cmd(3'd0, 32'hDEAD_BEEF, "R3 read4");
    xfer(8'h13, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 5);
    expect_cmd(3'd1, 32'h8000_0001, "R3 fread4");
    xfer(8'h0C, 8'h80, 8'h00, 8'h00, 8'h01, 5);
    expect_cmd(3'd2, 32'h0102_0304, "R3 prog4");
    xfer(8'h12, 8'h01, 8'h02, 8'h03, 8'h04, 5);
    expect_cmd(3'd3, 32'hFF00_FF00, "R3 erase4");
    xfer(8'hDC, 8'hFF, 8'h00, 8'hFF, 8'h00, 5);

    // R4 enter 4-byte state
    expect_cmd(3'd4, 32'h0, "R4 enter");
    xfer(8'hB7, 8'h00, 8'h00, 8'h00, 8'h00, 1);
    check(addr4_mode == 1'b1, "R4 mode set", 32'(addr4_mode), 32'd1);

    // R6 persistence across deselect; legacy now takes four bytes
    expect_cmd(3'd0, 32'h1122_3344, "R6 R4 read3 wide");
    xfer(8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 5);
    expect_cmd(3'd3, 32'hA5A5_5A5A, "R4 erase3 wide");
    xfer(8'hD8, 8'hA5, 8'hA5, 8'h5A, 8'h5A, 5);
    expect_cmd(3'd3, 32'h8000_0001, "R3 erase4 in wide state");
    xfer(8'hDC, 8'h80, 8'h00, 8'h00, 8'h01, 5);

    // R8 abort mid-address
    xfer(8'h03, 8'hAA, 8'hBB, 8'h00, 8'h00, 3);
    check(addr4_mode == 1'b1, "R8 mode kept after abort", 32'(addr4_mode), 32'd1);
    expect_cmd(3'd2, 32'h0506_0708, "R8 fresh opcode after abort");
    xfer(8'h02, 8'h05, 8'h06, 8'h07, 8'h08, 5);

    // R5 exit 4-byte state
    expect_cmd(3'd5, 32'h0, "R5 exit");
    xfer(8'hE9, 8'h00, 8'h00, 8'h00, 8'h00, 1);
    check(addr4_mode == 1'b0, "R5 mode cleared", 32'(addr4_mode), 32'd0);
    expect_cmd(3'd0, 32'h0000_0010, "R5 read3 narrow again");
    xfer(8'h03, 8'h00, 8'h00, 8'h10, 8'h00, 4);

    // R9 unknown opcode, rest ignored
    expect_inv("R9 unknown opcode");
    xfer(8'h9F, 8'h03, 8'h01, 8'h02, 8'h03, 5);
    expect_cmd(3'd0, 32'h0004_0506, "R9 recovers after deselect");
    xfer(8'h03, 8'h04, 8'h05, 8'h06, 8'h00, 4);

    // R10 trailing bytes ignored, including the enter opcode
    expect_cmd(3'd0, 32'h0001_0203, "R10 read then trailing bytes");
    xfer(8'h03, 8'h01, 8'h02, 8'h03, 8'hB7, 5);
    check(addr4_mode == 1'b0, "R10 trailing enter ignored", 32'(addr4_mode), 32'd0);

    // R7 reset clears the flag
    expect_cmd(3'd4, 32'h0, "R7 enter before reset");
    xfer(8'hB7, 8'h00, 8'h00, 8'h00, 8'h00, 1);
    check(addr4_mode == 1'b1, "R7 mode set before reset", 32'(addr4_mode), 32'd1);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(addr4_mode == 1'b0, "R7 mode cleared by reset", 32'(addr4_mode), 32'd0);
    expect_cmd(3'd2, 32'h0077_8899, "R7 legacy narrow after reset");
    xfer(8'h02, 8'h77, 8'h88, 8'h99, 8'h00, 4);

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R11 all expected reports seen", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule